// File: doc/BRIEF.md
# Shared Interrupt Source Controller

This controller sits between a set of external interrupt lines and several processor cores. Software programs it through a 32-bit register bus. Each line can be set to sense a level or an edge. Level sensing can be active high or active low. Edge sensing can catch one edge or both edges. The controller keeps one pending flag and one enable flag per line. Each line is steered to one output pin of one target core. A core's request output goes high whenever an enabled, pending line is steered to it.

Software can also force an edge-type line pending, or retire it, with a single write. This is how one core raises an interrupt on another core, and how a handler acknowledges a captured edge. The enable flags change only through two dedicated registers: one sets enables, the other clears them, one bit per line. A zero bit in either register leaves that line alone.

Top module: `shirq_ctrl`

## Requirements
- R1: A read of byte address 0x000 returns the capability word. Bits [7:0] hold NUM_SRC/8-1, bits [15:8] hold NUM_CORE-1, bits [23:16] hold NUM_PIN-1, and all other bits are 0.
- R2: After reset, every line is level-sensed, active-high (polarity bit 1), single-edge and disabled. Every line is steered to core 0, pin 0 with the steering valid flag set. All core outputs are low.
- R3: The per-line bit banks are grouped in 32-line words. Line i sits in word i/32, bit i%32, and words are 4 bytes apart. The banks start at these byte addresses: polarity 0x100, trigger 0x120 (1 = edge), dual-edge 0x140, pending 0x160 (read-only), enable 0x180 (read-only), enable-set 0x1A0, enable-clear 0x1C0. Bits for lines at or above NUM_SRC read as 0 and are not stored.
- R4: Writing a 1 to a bit of the enable-set word enables that line. Writing a 1 to the enable-clear word disables it. A 0 bit in either word leaves that line's enable unchanged.
- R5: For a level-sensed line, the pending flag is updated at every clock edge to (input == polarity bit). It therefore follows the input one clock later, in either polarity.
- R6: For an edge-sensed, single-edge line, the pending flag is set by a 0-to-1 input change when the polarity bit is 1, and by a 1-to-0 change when it is 0. It stays set until cleared by software.
- R7: For an edge-sensed line with dual-edge enabled, both input changes set pending, whatever the polarity bit holds.
- R8: A write to byte address 0x004 carries a line index in bits [7:0] and a flag in bit 31. Flag 1 sets the pending flag of that edge-sensed line; flag 0 clears it. A capture of a new edge in the same cycle wins over a clear.
- R9: Such a write has no effect on a level-sensed line. It also has no effect when the index is NUM_SRC or larger.
- R10: The pin steering word for line i is at byte 0x400 + 4*i, with bit 31 the valid flag and bits [7:0] the pin number. The core steering word is at byte 0x800 + 4*i, with bits [7:0] the core number.
- R11: Output core_pin_irq[c*NUM_PIN+p] is high exactly when some line is pending, enabled, steered to core c, steered to pin p, and has its valid flag set. core_irq[c] is the OR of that core's pins.
- R12: A line whose valid flag is clear, or whose pin number is NUM_PIN or larger, or whose core number is NUM_CORE or larger, drives no output.
- R13: bus_rdata takes the addressed word at the clock edge where bus_rd is high, and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_in | input | NUM_SRC | Raw interrupt lines |
| core_irq | output | NUM_CORE | Per-core request |
| core_pin_irq | output | NUM_CORE*NUM_PIN | Per-core, per-pin request |

## Verification
The bench builds the block with NUM_SRC=40, NUM_CORE=3 and NUM_PIN=4. Forty lines give a second bank word with only eight live bits, so the bench can check the truncated word and the zero reads above the top line. Three cores and four pins leave unused codes inside the 8-bit steering fields. A line can therefore be pointed at core 3 or pin 5, and the bench checks that it then drives nothing. An index of 50 also fits the injection field while lying past the last line.

// File: rtl/shirq_pkg.sv
package shirq_pkg;

    localparam int BUS_AW  = 12;
    localparam int BUS_DW  = 32;
    localparam int FIELD_W = 8;

    localparam logic [BUS_AW-1:0] A_CAPS    = 12'h000;
    localparam logic [BUS_AW-1:0] A_INJECT  = 12'h004;

    typedef enum logic [2:0] {
        BK_POL  = 3'd0,
        BK_TRIG = 3'd1,
        BK_DUAL = 3'd2,
        BK_PEND = 3'd3,
        BK_ENA  = 3'd4,
        BK_SETE = 3'd5,
        BK_CLRE = 3'd6,
        BK_RSVD = 3'd7
    } bank_e;

    typedef enum logic [2:0] {
        RG_NONE, RG_CAPS, RG_INJECT, RG_BANK, RG_PIN, RG_CORE
    } region_e;

    typedef struct packed {
        region_e              region;
        bank_e                bank;
        logic [2:0]           word;
        logic [FIELD_W-1:0]   idx;
    } dec_t;

    typedef struct packed {
        logic                 valid;
        logic                 set;
        logic [FIELD_W-1:0]   idx;
    } inject_t;

    function automatic dec_t decode(logic [BUS_AW-1:0] a);
        dec_t d;
        d.bank   = bank_e'(a[7:5]);
        d.word   = a[4:2];
        d.idx    = a[9:2];
        d.region = RG_NONE;
        if (a == A_CAPS)            d.region = RG_CAPS;
        else if (a == A_INJECT)     d.region = RG_INJECT;
        else if (a[11:8] == 4'h1)   d.region = RG_BANK;
        else if (a[11:10] == 2'b01) d.region = RG_PIN;
        else if (a[11:10] == 2'b10) d.region = RG_CORE;
        return d;
    endfunction

    function automatic logic edge_seen(logic prev, logic cur, logic pol_hi, logic both);
        if (both)   return prev ^ cur;
        if (pol_hi) return cur & ~prev;
        return prev & ~cur;
    endfunction

endpackage

// File: rtl/shirq_regs.sv
module shirq_regs
    import shirq_pkg::*;
#(
    parameter int NUM_SRC  = 64,
    parameter int NUM_CORE = 4,
    parameter int NUM_PIN  = 6
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              bus_wr,
    input  logic                              bus_rd,
    input  logic [BUS_AW-1:0]                 bus_addr,
    input  logic [BUS_DW-1:0]                 bus_wdata,
    output logic [BUS_DW-1:0]                 bus_rdata,
    input  logic [NUM_SRC-1:0]                pend,
    output logic [NUM_SRC-1:0]                pol_hi,
    output logic [NUM_SRC-1:0]                edge_mode,
    output logic [NUM_SRC-1:0]                dual_en,
    output logic [NUM_SRC-1:0]                ena,
    output logic [NUM_SRC-1:0]                pin_valid,
    output logic [NUM_SRC-1:0][FIELD_W-1:0]   pin_num,
    output logic [NUM_SRC-1:0][FIELD_W-1:0]   core_num,
    output inject_t                           inj
);

    dec_t               dec;
    logic [BUS_DW-1:0]  rd_word;
    logic [NUM_SRC-1:0] bank_vec;

    assign dec = decode(bus_addr);

    always_comb begin
        inj.valid = bus_wr && (dec.region == RG_INJECT)
                    && (int'(bus_wdata[FIELD_W-1:0]) < NUM_SRC);
        inj.set   = bus_wdata[31];
        inj.idx   = bus_wdata[FIELD_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_hi    <= '1;
            edge_mode <= '0;
            dual_en   <= '0;
            ena       <= '0;
            pin_valid <= '1;
            pin_num   <= '0;
            core_num  <= '0;
        end else if (bus_wr) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (dec.region == RG_BANK && int'(dec.word) == i / 32) begin
                    case (dec.bank)
                        BK_POL:  pol_hi[i]    <= bus_wdata[i % 32];
                        BK_TRIG: edge_mode[i] <= bus_wdata[i % 32];
                        BK_DUAL: dual_en[i]   <= bus_wdata[i % 32];
                        BK_SETE: if (bus_wdata[i % 32]) ena[i] <= 1'b1;
                        BK_CLRE: if (bus_wdata[i % 32]) ena[i] <= 1'b0;
                        default: ;
                    endcase
                end
                if (dec.region == RG_PIN && int'(dec.idx) == i) begin
                    pin_valid[i] <= bus_wdata[31];
                    pin_num[i]   <= bus_wdata[FIELD_W-1:0];
                end
                if (dec.region == RG_CORE && int'(dec.idx) == i)
                    core_num[i] <= bus_wdata[FIELD_W-1:0];
            end
        end
    end

    always_comb begin
        case (dec.bank)
            BK_POL:  bank_vec = pol_hi;
            BK_TRIG: bank_vec = edge_mode;
            BK_DUAL: bank_vec = dual_en;
            BK_PEND: bank_vec = pend;
            BK_ENA:  bank_vec = ena;
            default: bank_vec = '0;
        endcase
        rd_word = '0;
        case (dec.region)
            RG_CAPS: begin
                rd_word[7:0]   = 8'(NUM_SRC / 8 - 1);
                rd_word[15:8]  = 8'(NUM_CORE - 1);
                rd_word[23:16] = 8'(NUM_PIN - 1);
            end
            RG_BANK: begin
                for (int b = 0; b < 32; b++)
                    if (int'(dec.word) * 32 + b < NUM_SRC)
                        rd_word[b] = bank_vec[int'(dec.word) * 32 + b];
            end
            RG_PIN: begin
                for (int i = 0; i < NUM_SRC; i++)
                    if (int'(dec.idx) == i) begin
                        rd_word[31]          = pin_valid[i];
                        rd_word[FIELD_W-1:0] = pin_num[i];
                    end
            end
            RG_CORE: begin
                for (int i = 0; i < NUM_SRC; i++)
                    if (int'(dec.idx) == i)
                        rd_word[FIELD_W-1:0] = core_num[i];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_word;
    end

endmodule

// File: rtl/shirq_src.sv
module shirq_src
    import shirq_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [NUM_SRC-1:0] pol_hi,
    input  logic [NUM_SRC-1:0] edge_mode,
    input  logic [NUM_SRC-1:0] dual_en,
    input  inject_t            inj,
    output logic [NUM_SRC-1:0] pend
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_line
        logic prev_q;
        logic pend_q;
        logic hit;

        assign hit = inj.valid && (int'(inj.idx) == g);

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q <= 1'b0;
                pend_q <= 1'b0;
            end else begin
                prev_q <= irq_in[g];
                if (!edge_mode[g])
                    pend_q <= (irq_in[g] == pol_hi[g]);
                else if (edge_seen(prev_q, irq_in[g], pol_hi[g], dual_en[g]) || (hit && inj.set))
                    pend_q <= 1'b1;
                else if (hit)
                    pend_q <= 1'b0;
            end
        end

        assign pend[g] = pend_q;
    end

endmodule

// File: rtl/shirq_route.sv
module shirq_route
    import shirq_pkg::*;
#(
    parameter int NUM_SRC  = 64,
    parameter int NUM_CORE = 4,
    parameter int NUM_PIN  = 6
) (
    input  logic [NUM_SRC-1:0]              active,
    input  logic [NUM_SRC-1:0]              pin_valid,
    input  logic [NUM_SRC-1:0][FIELD_W-1:0] pin_num,
    input  logic [NUM_SRC-1:0][FIELD_W-1:0] core_num,
    output logic [NUM_CORE*NUM_PIN-1:0]     core_pin_irq,
    output logic [NUM_CORE-1:0]             core_irq
);

    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
        for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
            logic any;
            always_comb begin
                any = 1'b0;
                for (int i = 0; i < NUM_SRC; i++)
                    if (active[i] && pin_valid[i] && int'(pin_num[i]) == p
                        && int'(core_num[i]) == c)
                        any = 1'b1;
            end
            assign core_pin_irq[c*NUM_PIN+p] = any;
        end
        assign core_irq[c] = |core_pin_irq[c*NUM_PIN +: NUM_PIN];
    end

endmodule

// File: rtl/shirq_ctrl.sv
module shirq_ctrl
    import shirq_pkg::*;
#(
    parameter int NUM_SRC  = 64,
    parameter int NUM_CORE = 4,
    parameter int NUM_PIN  = 6
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [11:0]                   bus_addr,
    input  logic [31:0]                   bus_wdata,
    output logic [31:0]                   bus_rdata,
    input  logic [NUM_SRC-1:0]            irq_in,
    output logic [NUM_CORE-1:0]           core_irq,
    output logic [NUM_CORE*NUM_PIN-1:0]   core_pin_irq
);

    logic [NUM_SRC-1:0]              pend, pol_hi, edge_mode, dual_en, ena, pin_valid;
    logic [NUM_SRC-1:0][FIELD_W-1:0] pin_num, core_num;
    inject_t                         inj;
    logic [NUM_SRC-1:0]              active;

    assign active = pend & ena;

    shirq_regs #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .NUM_PIN(NUM_PIN)) regs_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pend(pend), .pol_hi(pol_hi), .edge_mode(edge_mode), .dual_en(dual_en),
        .ena(ena), .pin_valid(pin_valid), .pin_num(pin_num), .core_num(core_num),
        .inj(inj)
    );

    shirq_src #(.NUM_SRC(NUM_SRC)) src_i (
        .clk(clk), .rst(rst), .irq_in(irq_in), .pol_hi(pol_hi),
        .edge_mode(edge_mode), .dual_en(dual_en), .inj(inj), .pend(pend)
    );

    shirq_route #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .NUM_PIN(NUM_PIN)) route_i (
        .active(active), .pin_valid(pin_valid), .pin_num(pin_num),
        .core_num(core_num), .core_pin_irq(core_pin_irq), .core_irq(core_irq)
    );

endmodule

// File: rtl/shirq_ctrl_chk.sv
module shirq_ctrl_chk
    import shirq_pkg::*;
#(
    parameter int NUM_SRC  = 64,
    parameter int NUM_CORE = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bus_wr,
    input logic [11:0]           bus_addr,
    input logic [31:0]           bus_wdata,
    input logic [NUM_SRC-1:0]    irq_in,
    input logic [NUM_SRC-1:0]    pend,
    input logic [NUM_SRC-1:0]    ena,
    input logic [NUM_SRC-1:0]    pol_hi,
    input logic [NUM_SRC-1:0]    edge_mode,
    input inject_t               inj,
    input logic [NUM_CORE-1:0]   core_irq
);

    logic [31:0]        ena_w0, live_w0;
    logic [NUM_SRC-1:0] set_sel;

    for (genvar b = 0; b < 32; b++) begin : g_w0
        if (b < NUM_SRC) begin : g_live
            assign ena_w0[b]  = ena[b];
            assign live_w0[b] = 1'b1;
        end else begin : g_dead
            assign ena_w0[b]  = 1'b0;
            assign live_w0[b] = 1'b0;
        end
    end

    always_comb begin
        set_sel = '0;
        for (int i = 0; i < NUM_SRC; i++)
            if (inj.valid && inj.set && int'(inj.idx) == i && edge_mode[i])
                set_sel[i] = 1'b1;
    end

    // R11
    core_needs_line_chk: assert property (@(posedge clk) disable iff (rst)
        (core_irq != '0) |-> ((pend & ena) != '0));

    // R4
    ena_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 12'h1A0) |=>
        ((ena_w0 & $past(bus_wdata) & live_w0) == ($past(bus_wdata) & live_w0)));

    // R4
    ena_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 12'h1C0) |=> ((ena_w0 & $past(bus_wdata)) == '0));

    // R5
    level_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !edge_mode[0] |=> (pend[0] == ($past(irq_in[0]) == $past(pol_hi[0]))));

    // R8
    inject_set_chk: assert property (@(posedge clk) disable iff (rst)
        (set_sel != '0) |=> ((pend & $past(set_sel)) == $past(set_sel)));

endmodule

bind shirq_ctrl shirq_ctrl_chk #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE)) chk_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .irq_in(irq_in), .pend(pend), .ena(ena),
    .pol_hi(pol_hi), .edge_mode(edge_mode), .inj(inj), .core_irq(core_irq)
);

// File: tb/shirq_ctrl_tb.sv
module shirq_ctrl_tb_top;

    localparam int NS = 40;
    localparam int NC = 3;
    localparam int NP = 4;

    logic                clk = 1'b0;
    logic                rst;
    logic                bus_wr, bus_rd;
    logic [11:0]         bus_addr;
    logic [31:0]         bus_wdata;
    logic [31:0]         bus_rdata;
    logic [NS-1:0]       irq_in;
    logic [NC-1:0]       core_irq;
    logic [NC*NP-1:0]    core_pin_irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    shirq_ctrl #(.NUM_SRC(NS), .NUM_CORE(NC), .NUM_PIN(NP)) dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .core_irq(core_irq), .core_pin_irq(core_pin_irq)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(core_irq == '0, "R2", 32'(core_irq), 0);
        chk(core_pin_irq == '0, "R2", 32'(core_pin_irq), 0);
        rd(12'h180, rv); chk(rv == 0, "R2", rv, 0);
        rd(12'h100, rv); chk(rv == 32'hFFFF_FFFF, "R2", rv, 32'hFFFF_FFFF);
        rd(12'h104, rv); chk(rv == 32'h0000_00FF, "R3", rv, 32'h0000_00FF);
        rd(12'h120, rv); chk(rv == 0, "R2", rv, 0);
        rd(12'h414, rv); chk(rv == 32'h8000_0000, "R2", rv, 32'h8000_0000);
        rd(12'h814, rv); chk(rv == 0, "R2", rv, 0);
    endtask

    task automatic t_caps();
        rd(12'h000, rv); chk(rv == 32'h0003_0204, "R1", rv, 32'h0003_0204);
    endtask

    task automatic t_enable();
        wr(12'h1A0, 32'h5);
        rd(12'h180, rv); chk(rv == 32'h5, "R4", rv, 32'h5);
        wr(12'h1A0, 32'h2);
        rd(12'h180, rv); chk(rv == 32'h7, "R4", rv, 32'h7);
        wr(12'h1C0, 32'h4);
        rd(12'h180, rv); chk(rv == 32'h3, "R4", rv, 32'h3);
        wr(12'h1A4, 32'h81);
        rd(12'h184, rv); chk(rv == 32'h81, "R3", rv, 32'h81);
        wr(12'h1A4, 32'hFFFF_FFFF);
        rd(12'h184, rv); chk(rv == 32'hFF, "R3", rv, 32'hFF);
        wr(12'h1C0, 32'hFFFF_FFFF);
        wr(12'h1C4, 32'hFFFF_FFFF);
        rd(12'h180, rv); chk(rv == 0, "R4", rv, 0);
    endtask

    task automatic t_level();
        wr(12'h1A0, 32'h8);
        @(negedge clk); irq_in[3] = 1'b1;
        tick();
        chk(core_irq == 3'b001, "R5", 32'(core_irq), 1);
        chk(core_pin_irq == 12'h001, "R11", 32'(core_pin_irq), 1);
        rd(12'h160, rv); chk(rv == 32'h8, "R5", rv, 32'h8);
        irq_in[3] = 1'b0;
        tick();
        chk(core_irq == 0, "R5", 32'(core_irq), 0);
        wr(12'h100, 32'hFFFF_FFF7);
        tick();
        chk(core_irq == 3'b001, "R5", 32'(core_irq), 1);
        wr(12'h100, 32'hFFFF_FFFF);
        tick();
        chk(core_irq == 0, "R5", 32'(core_irq), 0);
        wr(12'h1C0, 32'h8);
    endtask

    task automatic t_edge();
        wr(12'h120, 32'h0010_0C00);
        wr(12'h828, 32'h1);
        wr(12'h428, 32'h8000_0002);
        wr(12'h1A0, 32'h400);
        @(negedge clk); irq_in[10] = 1'b1;
        tick();
        chk(core_pin_irq == 12'h040, "R6", 32'(core_pin_irq), 32'h40);
        chk(core_irq == 3'b010, "R11", 32'(core_irq), 2);
        irq_in[10] = 1'b0;
        tick();
        chk(core_irq == 3'b010, "R6", 32'(core_irq), 2);
        wr(12'h004, 32'h0000_000A);
        chk(core_irq == 0, "R8", 32'(core_irq), 0);
        irq_in[10] = 1'b1; tick(); wr(12'h004, 32'h0000_000A);
        irq_in[10] = 1'b0; tick(); tick();
        chk(core_irq == 0, "R6", 32'(core_irq), 0);
        wr(12'h100, 32'hFFFF_FBFF);
        irq_in[10] = 1'b1; tick(); tick();
        chk(core_irq == 0, "R6", 32'(core_irq), 0);
        irq_in[10] = 1'b0; tick();
        chk(core_irq == 3'b010, "R6", 32'(core_irq), 2);
        wr(12'h004, 32'h0000_000A);
        wr(12'h100, 32'hFFFF_FFFF);
        wr(12'h1C0, 32'h400);
    endtask

    task automatic t_dual();
        wr(12'h140, 32'h800);
        wr(12'h1A0, 32'h800);
        @(negedge clk); irq_in[11] = 1'b1;
        tick();
        chk(core_irq == 3'b001, "R7", 32'(core_irq), 1);
        wr(12'h004, 32'h0000_000B);
        chk(core_irq == 0, "R8", 32'(core_irq), 0);
        irq_in[11] = 1'b0;
        tick();
        chk(core_irq == 3'b001, "R7", 32'(core_irq), 1);
        wr(12'h004, 32'h0000_000B);
        wr(12'h1C0, 32'h800);
    endtask

    task automatic t_inject();
        wr(12'h1A0, 32'h0030_0000);
        wr(12'h004, 32'h8000_0014);
        chk(core_irq == 3'b001, "R8", 32'(core_irq), 1);
        rd(12'h160, rv); chk(rv == 32'h0010_0000, "R8", rv, 32'h0010_0000);
        wr(12'h004, 32'h8000_0015);
        rd(12'h160, rv); chk(rv == 32'h0010_0000, "R9", rv, 32'h0010_0000);
        wr(12'h004, 32'h0000_0014);
        wr(12'h004, 32'h8000_0032);
        chk(core_irq == 0, "R9", 32'(core_irq), 0);
        rd(12'h160, rv); chk(rv == 0, "R9", rv, 0);
        rd(12'h164, rv); chk(rv == 0, "R9", rv, 0);
    endtask

    task automatic t_route();
        wr(12'h004, 32'h8000_0014);
        wr(12'h450, 32'h0000_0001);
        chk(core_irq == 0 && core_pin_irq == 0, "R12", 32'(core_pin_irq), 0);
        rd(12'h160, rv); chk(rv == 32'h0010_0000, "R12", rv, 32'h0010_0000);
        wr(12'h450, 32'h8000_0005);
        chk(core_pin_irq == 0, "R12", 32'(core_pin_irq), 0);
        wr(12'h450, 32'h8000_0003);
        chk(core_pin_irq == 12'h008, "R10", 32'(core_pin_irq), 8);
        rd(12'h450, rv); chk(rv == 32'h8000_0003, "R10", rv, 32'h8000_0003);
        wr(12'h850, 32'h2);
        chk(core_irq == 3'b100 && core_pin_irq == 12'h800, "R10", 32'(core_pin_irq), 32'h800);
        wr(12'h850, 32'h3);
        chk(core_irq == 0, "R12", 32'(core_irq), 0);
        rd(12'h850, rv); chk(rv == 32'h3, "R10", rv, 3);
    endtask

    task automatic t_read_hold();
        rd(12'h000, rv);
        tick(); tick();
        chk(bus_rdata == 32'h0003_0204, "R13", bus_rdata, 32'h0003_0204);
    endtask

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0; irq_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick();
        t_reset();
        t_caps();
        t_enable();
        t_level();
        t_edge();
        t_dual();
        t_inject();
        t_route();
        t_read_hold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule